// File: doc/BRIEF.md
# Floppy Controller Host Register Interface

This block is the host-facing register slice of a floppy disk controller. A processor reaches it through a chip select, active-low read and write strobes, a 3-bit address and an 8-bit data bus. Inside it keeps an output control register that selects a drive and enables motors. It also keeps one data-rate value, which two write-only registers share. From these it drives the four drive-select outputs, the motor enables, the two rate pins and the density pin. The DMA request and acknowledge pair is gated according to a mode strap. Drive status inputs are multiplexed back onto the read bus.

Host strobes are sampled on the block clock by a small access sequencer with four states. IDLE waits for a qualified strobe. WRITE holds while the write strobe is low and keeps capturing address and data. COMMIT is a single cycle that applies the captured write. READ drives the bus while the read strobe stays low. The transitions are:

- START_WRITE: IDLE to WRITE, on a qualified write strobe; this has priority over a read.
- START_READ: IDLE to READ, on a qualified read strobe.
- STROBE_RISE: WRITE to COMMIT, when the write strobe goes high.
- ABORT: WRITE to IDLE, when qualification is lost with the strobe still low.
- RETIRE: COMMIT to IDLE, unconditionally.
- READ_END: READ to IDLE, when the read strobe rises or qualification drops.

A strobe is qualified as a register access only when the chip select is low and no enabled DMA acknowledge is present. During an acknowledged DMA cycle the address lines are ignored and the strobes are passed to the transfer logic as DMA read and write pulses.

Top module: `fdc_host_ctrl`

## Requirements
- R1: After reset the output control register and the rate value are zero, so every drive select and motor output is low, `rate_out` is 00 and `dout_oe` is low.
- R2: A register write is applied only after the write strobe rises, and only if `host_sel_n` was low with no enabled DMA acknowledge while the strobe was low; a write with `host_sel_n` high leaves every register unchanged.
- R3: `drv_sel[n]` is high exactly when output control bits 1:0 equal n and output control bit 4+n is set; `motor_on[3:0]` equals output control bits 7:4 (register at offset 2, readable back at offset 2).
- R4: With `gated_dma_mode` high, `dma_req` equals `fifo_req` AND output control bit 3, and `dma_ack_n` has no effect while bit 3 is clear; with `gated_dma_mode` low, both are always enabled.
- R5: `rate_out` takes data bits 1:0 of whichever write came last, to the rate-select register (offset 4) or the configuration register (offset 7); other data bits are discarded. Codes: 00 = 500 kb/s, 01 = 300 kb/s, 10 = 250 kb/s, 11 = 1 Mb/s.
- R6: Codes 00 and 11 are high density. With `drv_type_strap` high, `hd_sel` is high for high density; with it low, `hd_sel` is low for high density.
- R7: When `dens_ovr_en` is high, `hd_sel` equals `dens_ovr_val` whatever the rate and strap.
- R8: A read at offset 7 returns `door_changed` in bit 7 and zeros elsewhere. A read at offset 0 returns `second_drive` in bit 6 when `gated_dma_mode` is low, and 0x00 when it is high. A read at offset 4 returns 0x00.
- R9: `dout_oe` is high only while a qualified register read is in progress: `host_sel_n` low, `rd_n` low, and no enabled DMA acknowledge.
- R10: With `dma_ack_n` low and DMA enabled, `dma_rd`/`dma_wr` follow the low read/write strobe. The address is ignored, no register is written and `dout_oe` stays low.
- R11: `step_dir` is low whenever `xfer_active` is high, and follows `seek_dir` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel_n | input | 1 | Active-low chip select for register access |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 3 | Register offset |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| dout_oe | output | 1 | Read data enable toward the bus |
| dma_ack_n | input | 1 | Active-low DMA acknowledge |
| dma_req | output | 1 | Gated DMA request |
| dma_rd | output | 1 | Acknowledged DMA read strobe |
| dma_wr | output | 1 | Acknowledged DMA write strobe |
| fifo_req | input | 1 | Ungated transfer request from the FIFO logic |
| gated_dma_mode | input | 1 | Strap: 1 = DMA gated by control bit 3, 0 = always enabled |
| drv_type_strap | input | 1 | Strap selecting density pin polarity |
| dens_ovr_en | input | 1 | Density override enable from mode setting |
| dens_ovr_val | input | 1 | Density override level |
| door_changed | input | 1 | Drive door-change status |
| second_drive | input | 1 | Second-drive-installed status |
| seek_dir | input | 1 | Step direction from seek logic |
| xfer_active | input | 1 | High during data read or write |
| drv_sel | output | 4 | Decoded, motor-gated drive selects |
| motor_on | output | 4 | Motor enables |
| rate_out | output | 2 | Current data-rate code |
| hd_sel | output | 1 | Density select pin |
| step_dir | output | 1 | Step direction pin |

## Verification
Every cycle, the embedded properties check a set of port relations. The bus enable never rises outside a low chip select and read strobe. An enabled DMA acknowledge always keeps the bus undriven. A commit follows a strobe that was seen low and then high. The rate value moves only on a commit. A DMA request never appears without its source and enable. At most one drive select is active, and never without its motor. The step direction is idle during transfers. Which register the last write landed in, the ignored chip-deselected and DMA writes, and the readback value at each offset under each strap can be shown only by the bench's ordered scenarios. That includes the rate register written last winning and the density polarity under each strap.

// File: rtl/fdc_host_pkg.sv
`timescale 1ns/1ps
package fdc_host_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_WRITE  = 2'd1,
        ACC_COMMIT = 2'd2,
        ACC_READ   = 2'd3
    } acc_state_t;

    // register offsets (decoded by neighbours' software)
    localparam int OFS_STAT_A   = 0;
    localparam int OFS_OUT_CTL  = 2;
    localparam int OFS_RATE_SEL = 4;
    localparam int OFS_IN_CFG   = 7;

    // rate codes
    localparam logic [1:0] RATE_500K = 2'b00;
    localparam logic [1:0] RATE_300K = 2'b01;
    localparam logic [1:0] RATE_250K = 2'b10;
    localparam logic [1:0] RATE_1M   = 2'b11;

    localparam int STAT_A_DRV2_BIT = 6;
    localparam int OUT_CTL_DMA_BIT = 3;

    function automatic logic is_high_density(input logic [1:0] code);
        return (code == RATE_500K) || (code == RATE_1M);
    endfunction

endpackage

// File: rtl/fdc_access_fsm.sv
`timescale 1ns/1ps
module fdc_access_fsm
    import fdc_host_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_qual,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output logic              rd_oe
);

    acc_state_t state, state_nxt;
    logic       capture;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ACC_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ACC_IDLE: begin
                if (reg_qual && !wr_n)      state_nxt = ACC_WRITE;  // START_WRITE
                else if (reg_qual && !rd_n) state_nxt = ACC_READ;   // START_READ
            end
            ACC_WRITE: begin
                if (wr_n)           state_nxt = ACC_COMMIT;         // STROBE_RISE
                else if (!reg_qual) state_nxt = ACC_IDLE;           // ABORT
            end
            ACC_COMMIT: state_nxt = ACC_IDLE;                       // RETIRE
            ACC_READ: begin
                if (rd_n || !reg_qual) state_nxt = ACC_IDLE;        // READ_END
            end
        endcase
    end

    // outputs
    always_comb begin
        commit  = (state == ACC_COMMIT);
        rd_oe   = (state == ACC_READ) && !rd_n && reg_qual;
        capture = reg_qual && !wr_n &&
                  ((state == ACC_IDLE) || (state == ACC_WRITE));
    end

    // address and data held from the last low-strobe cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_addr <= '0;
            commit_data <= '0;
        end else if (capture) begin
            commit_addr <= addr;
            commit_data <= din;
        end
    end

    // R2: a commit follows a strobe sampled low then high
    a_r2_commit_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(wr_n) && !$past(wr_n, 2)));

    // R9: no bus drive outside a low read strobe
    a_r9_oe_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> !rd_n);

endmodule

// File: rtl/fdc_host_regs.sv
`timescale 1ns/1ps
module fdc_host_regs
    import fdc_host_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic [DATA_W-1:0] commit_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              gated_dma_mode,
    input  logic              door_changed,
    input  logic              second_drive,
    output logic [DATA_W-1:0] out_ctl,
    output logic [RATE_W-1:0] rate,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT_A);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUT_CTL);
    localparam logic [ADDR_W-1:0] A_RATE = ADDR_W'(OFS_RATE_SEL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_IN_CFG);

    logic hit_out, hit_rate;

    always_comb begin
        hit_out  = commit && (commit_addr == A_OUT);
        hit_rate = commit && ((commit_addr == A_RATE) || (commit_addr == A_CFG));
    end

    // one shared rate value: whichever register was written last wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_ctl <= '0;
            rate    <= '0;
        end else begin
            if (hit_out)  out_ctl <= commit_data;
            if (hit_rate) rate    <= commit_data[RATE_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_STAT: if (!gated_dma_mode) rd_data[STAT_A_DRV2_BIT] = second_drive;
            A_OUT:  rd_data = out_ctl;
            A_CFG:  rd_data[DATA_W-1] = door_changed;
            default: rd_data = '0;
        endcase
    end

    // R5: rate holds unless a commit lands
    a_r5_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(rate));

    // R2: output control only changes after a commit
    a_r2_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(out_ctl));

endmodule

// File: rtl/fdc_drive_pins.sv
`timescale 1ns/1ps
module fdc_drive_pins
    import fdc_host_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int RATE_W     = 2,
    localparam int SEL_W     = $clog2(NUM_DRIVES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      sel_code,
    input  logic [NUM_DRIVES-1:0] motor_bits,
    input  logic                  dma_bit,
    input  logic [RATE_W-1:0]     rate,
    input  logic                  gated_dma_mode,
    input  logic                  drv_type_strap,
    input  logic                  dens_ovr_en,
    input  logic                  dens_ovr_val,
    input  logic                  seek_dir,
    input  logic                  xfer_active,
    input  logic                  fifo_req,
    output logic [NUM_DRIVES-1:0] drv_sel,
    output logic [NUM_DRIVES-1:0] motor_on,
    output logic                  dma_en,
    output logic                  dma_req,
    output logic                  hd_sel,
    output logic                  step_dir
);

    logic high_dens;

    generate
        for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_sel
            assign drv_sel[i]  = (sel_code == SEL_W'(i)) && motor_bits[i];
            assign motor_on[i] = motor_bits[i];

            // R3: a selected drive always has its motor enabled
            a_r3_sel_has_motor: assert property (@(posedge clk) disable iff (!rst_n)
                drv_sel[i] |-> motor_on[i]);
        end
    endgenerate

    always_comb begin
        dma_en    = gated_dma_mode ? dma_bit : 1'b1;
        dma_req   = fifo_req && dma_en;
        high_dens = is_high_density(rate[1:0]);
        if (dens_ovr_en)         hd_sel = dens_ovr_val;
        else if (drv_type_strap) hd_sel = high_dens;
        else                     hd_sel = !high_dens;
        step_dir  = xfer_active ? 1'b0 : seek_dir;
    end

    // R3: at most one drive selected
    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_sel));

    // R4: request never without source and enable
    a_r4_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (fifo_req && (!gated_dma_mode || dma_bit)));

    // R11: direction idle during transfers
    a_r11_dir_idle: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |-> !step_dir);

endmodule

// File: rtl/fdc_host_ctrl.sv
`timescale 1ns/1ps
module fdc_host_ctrl
    import fdc_host_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 3,
    parameter int NUM_DRIVES = 4,
    parameter int RATE_W     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_sel_n,
    input  logic                  rd_n,
    input  logic                  wr_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     din,
    output logic [DATA_W-1:0]     dout,
    output logic                  dout_oe,
    input  logic                  dma_ack_n,
    output logic                  dma_req,
    output logic                  dma_rd,
    output logic                  dma_wr,
    input  logic                  fifo_req,
    input  logic                  gated_dma_mode,
    input  logic                  drv_type_strap,
    input  logic                  dens_ovr_en,
    input  logic                  dens_ovr_val,
    input  logic                  door_changed,
    input  logic                  second_drive,
    input  logic                  seek_dir,
    input  logic                  xfer_active,
    output logic [NUM_DRIVES-1:0] drv_sel,
    output logic [NUM_DRIVES-1:0] motor_on,
    output logic [RATE_W-1:0]     rate_out,
    output logic                  hd_sel,
    output logic                  step_dir
);

    localparam int SEL_W     = $clog2(NUM_DRIVES);
    localparam int MOTOR_LSB = DATA_W - NUM_DRIVES;

    logic              dma_en, dma_ack_act, reg_qual;
    logic              commit, rd_oe;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data, out_ctl, rd_data;

    always_comb begin
        dma_ack_act = !dma_ack_n && dma_en;
        reg_qual    = !host_sel_n && !dma_ack_act;
        dma_rd      = dma_ack_act && !rd_n;
        dma_wr      = dma_ack_act && !wr_n;
        dout_oe     = rd_oe;
        dout        = rd_oe ? rd_data : '0;
    end

    fdc_access_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .reg_qual(reg_qual), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .commit(commit), .commit_addr(commit_addr),
        .commit_data(commit_data), .rd_oe(rd_oe)
    );

    fdc_host_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RATE_W(RATE_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .commit_addr(commit_addr),
        .commit_data(commit_data), .rd_addr(addr), .gated_dma_mode(gated_dma_mode),
        .door_changed(door_changed), .second_drive(second_drive),
        .out_ctl(out_ctl), .rate(rate_out), .rd_data(rd_data)
    );

    fdc_drive_pins #(.NUM_DRIVES(NUM_DRIVES), .RATE_W(RATE_W)) i_pins (
        .clk(clk), .rst_n(rst_n),
        .sel_code(out_ctl[SEL_W-1:0]),
        .motor_bits(out_ctl[MOTOR_LSB +: NUM_DRIVES]),
        .dma_bit(out_ctl[OUT_CTL_DMA_BIT]),
        .rate(rate_out), .gated_dma_mode(gated_dma_mode),
        .drv_type_strap(drv_type_strap), .dens_ovr_en(dens_ovr_en),
        .dens_ovr_val(dens_ovr_val), .seek_dir(seek_dir), .xfer_active(xfer_active),
        .fifo_req(fifo_req), .drv_sel(drv_sel), .motor_on(motor_on),
        .dma_en(dma_en), .dma_req(dma_req), .hd_sel(hd_sel), .step_dir(step_dir)
    );

    // R9: bus driven only under a low chip select and read strobe
    a_r9_oe_port_qual: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!host_sel_n && !rd_n));

    // R10: an acknowledged DMA cycle never drives register data
    a_r10_dma_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd || dma_wr) |-> !dout_oe);

endmodule

// File: tb/test_fdc_host_ctrl.sv
`timescale 1ns/1ps
module test_fdc_host_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_sel_n, rd_n, wr_n, dma_ack_n, fifo_req;
    logic [2:0] addr;
    logic [7:0] din, dout;
    logic       dout_oe, dma_req, dma_rd, dma_wr;
    logic       gated_dma_mode, drv_type_strap, dens_ovr_en, dens_ovr_val;
    logic       door_changed, second_drive, seek_dir, xfer_active;
    logic [3:0] drv_sel, motor_on;
    logic [1:0] rate_out;
    logic       hd_sel, step_dir;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];
    logic       oe_seen = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    fdc_host_ctrl i_fdc_host_ctrl (
        .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .dma_ack_n(dma_ack_n),
        .dma_req(dma_req), .dma_rd(dma_rd), .dma_wr(dma_wr), .fifo_req(fifo_req),
        .gated_dma_mode(gated_dma_mode), .drv_type_strap(drv_type_strap),
        .dens_ovr_en(dens_ovr_en), .dens_ovr_val(dens_ovr_val),
        .door_changed(door_changed), .second_drive(second_drive),
        .seek_dir(seek_dir), .xfer_active(xfer_active), .drv_sel(drv_sel),
        .motor_on(motor_on), .rate_out(rate_out), .hd_sel(hd_sel), .step_dir(step_dir)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d, input logic sel_lo);
        @(negedge clk);
        addr = a; din = d; host_sel_n = !sel_lo; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        host_sel_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // driver: pushes the expected byte, monitor compares it
    task automatic host_read(input logic [2:0] a, input logic [7:0] exp, input string req);
        exp_q.push_back(exp);
        req_q.push_back(req);
        @(negedge clk);
        addr = a; host_sel_n = 1'b0; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        rd_n = 1'b1; host_sel_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (dout_oe && !oe_seen) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected bus drive", 8'h01, 8'h00);
            end else begin
                check(req_q.pop_front(), dout, exp_q.pop_front());
            end
        end
        oe_seen = dout_oe;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; host_sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; dma_ack_n = 1'b1;
        addr = '0; din = '0; fifo_req = 1'b0; gated_dma_mode = 1'b1; drv_type_strap = 1'b1;
        dens_ovr_en = 1'b0; dens_ovr_val = 1'b0; door_changed = 1'b0; second_drive = 1'b0;
        seek_dir = 1'b1; xfer_active = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        check("R1 drv_sel", {4'h0, drv_sel}, 8'h00);
        check("R1 motor_on", {4'h0, motor_on}, 8'h00);
        check("R1 rate_out", {6'h0, rate_out}, 8'h00);
        check("R1 dout_oe", {7'h0, dout_oe}, 8'h00);
        host_read(3'd2, 8'h00, "R1 control readback");

        // R3 decode with motor gating
        host_write(3'd2, 8'h12, 1'b1); settle();
        check("R3 sel 2 motor off", {4'h0, drv_sel}, 8'h00);
        check("R3 motor bits", {4'h0, motor_on}, 8'h01);
        host_write(3'd2, 8'h42, 1'b1); settle();
        check("R3 sel 2 motor on", {4'h0, drv_sel}, 8'h04);
        host_write(3'd2, 8'hF3, 1'b1); settle();
        check("R3 sel 3", {4'h0, drv_sel}, 8'h08);
        host_read(3'd2, 8'hF3, "R3 control readback");

        // R2 write with chip select high is ignored
        host_write(3'd2, 8'h00, 1'b0); settle();
        check("R2 deselected write drv_sel", {4'h0, drv_sel}, 8'h08);
        host_read(3'd2, 8'hF3, "R2 deselected write readback");

        // R4 DMA gating, control bit 3 clear
        fifo_req = 1'b1; settle();
        check("R4 req gated off", {7'h0, dma_req}, 8'h00);
        dma_ack_n = 1'b0; rd_n = 1'b0; settle();
        check("R4 ack ignored", {7'h0, dma_rd}, 8'h00);
        rd_n = 1'b1; dma_ack_n = 1'b1;
        host_write(3'd2, 8'hFB, 1'b1); settle();
        check("R4 req enabled", {7'h0, dma_req}, 8'h01);
        gated_dma_mode = 1'b0;
        host_write(3'd2, 8'hF3, 1'b1); settle();
        check("R4 alternate mode always enabled", {7'h0, dma_req}, 8'h01);
        gated_dma_mode = 1'b1;
        host_write(3'd2, 8'hFB, 1'b1);

        // R10 DMA cycles ignore address and registers
        @(negedge clk);
        dma_ack_n = 1'b0; host_sel_n = 1'b0; addr = 3'd2; din = 8'h00; wr_n = 1'b0;
        settle();
        check("R10 dma_wr", {7'h0, dma_wr}, 8'h01);
        wr_n = 1'b1; rd_n = 1'b0; settle();
        check("R10 dma_rd", {7'h0, dma_rd}, 8'h01);
        check("R10 no bus drive", {7'h0, dout_oe}, 8'h00);
        rd_n = 1'b1; host_sel_n = 1'b1; dma_ack_n = 1'b1;
        repeat (2) @(negedge clk);
        host_read(3'd2, 8'hFB, "R10 control unchanged by DMA write");
        fifo_req = 1'b0;

        // R5 rate written last wins, R6 density
        host_write(3'd4, 8'h02, 1'b1); settle();
        check("R5 rate via offset 4", {6'h0, rate_out}, 8'h02);
        check("R6 250k strap high", {7'h0, hd_sel}, 8'h00);
        drv_type_strap = 1'b0; settle();
        check("R6 250k strap low", {7'h0, hd_sel}, 8'h01);
        host_write(3'd7, 8'h01, 1'b1); settle();
        check("R5 rate via offset 7", {6'h0, rate_out}, 8'h01);
        host_write(3'd4, 8'h03, 1'b1); settle();
        check("R5 rate offset 4 again", {6'h0, rate_out}, 8'h03);
        check("R6 1M strap low", {7'h0, hd_sel}, 8'h00);
        host_write(3'd7, 8'hFC, 1'b1); settle();
        check("R5 only bits 1:0", {6'h0, rate_out}, 8'h00);
        drv_type_strap = 1'b1; settle();
        check("R6 500k strap high", {7'h0, hd_sel}, 8'h01);

        // R7 override
        dens_ovr_en = 1'b1; dens_ovr_val = 1'b0; settle();
        check("R7 override low", {7'h0, hd_sel}, 8'h00);
        dens_ovr_en = 1'b0;

        // R8 read mux
        door_changed = 1'b1;
        host_read(3'd7, 8'h80, "R8 door changed set");
        door_changed = 1'b0;
        host_read(3'd7, 8'h00, "R8 door changed clear");
        second_drive = 1'b1; gated_dma_mode = 1'b0;
        host_read(3'd0, 8'h40, "R8 status A alternate mode");
        gated_dma_mode = 1'b1;
        host_read(3'd0, 8'h00, "R8 status A gated mode");
        host_read(3'd4, 8'h00, "R8 offset 4 write-only");

        // R9 no drive while deselected
        @(negedge clk);
        addr = 3'd2; rd_n = 1'b0; host_sel_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check("R9 deselected read", {7'h0, dout_oe}, 8'h00);
        rd_n = 1'b1;

        // R11 step direction
        xfer_active = 1'b1; settle();
        check("R11 idle during transfer", {7'h0, step_dir}, 8'h00);
        xfer_active = 1'b0; settle();
        check("R11 follows seek", {7'h0, step_dir}, 8'h01);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) check("R9 reads never served", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule